// File: doc/BRIEF.md
# Memory Self-Test Failure Logger

This block sits beside the compare stage of a memory self-test engine and keeps a record of what went wrong during a run. Each cycle the engine may present a compare strobe together with the address under test, the data it expected and the data it read back. Any compare where the two data words differ is a failure.

Across the whole run the logger builds a mask with one bit per data bit position. A bit in this mask is set once that position has differed in at least one compare. The logger also raises a sticky fail flag and stores the address and read data of the earliest failures in a small bank of capture slots, five by default. A saturating counter reports how many slots hold a failure. Software or a debug controller reads the slots through a plain index-in, data-out port.

A start pulse at the beginning of each run clears every piece of recorded state.

Top module: `fail_log_capture`

## Requirements
- R1: After reset, the mask, the fail flag and the count are all zero, and every capture slot reads back as zero.
- R2: On each accepted compare, the mask becomes its old value ORed with the bitwise XOR of expected and read data. The new mask is visible after the next rising clock edge.
- R3: The fail flag goes high at the clock edge of the first accepted compare whose data words differ. It then stays high until a start pulse or reset.
- R4: A cycle with the compare strobe low changes neither the mask, the flag, the count nor any capture slot, whatever the address and data inputs carry.
- R5: The n-th failure of a run (n = 1..SLOTS) stores its address and its read data in slot index n-1. The count then reads n.
- R6: The count saturates at SLOTS (5 by default). Failures beyond that still update the mask and the flag, but leave every slot unchanged.
- R7: A start pulse clears the mask, the flag, the count and all slots at the next edge. It takes priority over a compare presented in the same cycle, and that compare is discarded.
- R8: The read port is combinational. For an index 0..SLOTS-1 it shows that slot's address and data. For any index of SLOTS or above it shows zero.
- R9: An accepted compare whose expected and read data are equal changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_start | input | 1 | Pulse that clears all recorded state for a new run |
| cmp_valid | input | 1 | Compare strobe; a compare is present this cycle |
| cmp_addr | input | ADDR_W | Address of the compared location |
| cmp_exp | input | DATA_W | Expected data |
| cmp_rd | input | DATA_W | Data read from memory |
| rd_idx | input | IDX_W | Capture slot index for the read port |
| bit_fail_mask | output | DATA_W | Accumulated failing bit positions |
| fail_flag | output | 1 | Sticky: at least one failure this run |
| fail_count | output | CNT_W | Number of filled capture slots, 0..SLOTS |
| rd_addr | output | ADDR_W | Address held in the selected slot |
| rd_data | output | DATA_W | Read data held in the selected slot |

## Verification
The assertions assume that rst_n is released synchronously to the clock. They also assume that run_start and cmp_valid are driven only from clocked logic, so no input changes near an edge. They place no constraint on how often the start pulse or compares arrive, or on how the two overlap.

The bench drives every input on the falling edge. It mixes random strobes, random data with a tunable share of exact matches, and rare start pulses that sometimes coincide with a compare. This stays inside those assumptions while reaching saturation and the clear-versus-compare collision.

// File: rtl/fl_pkg.sv
package fl_pkg;

  localparam int FL_DATA_W = 16;
  localparam int FL_ADDR_W = 12;
  localparam int FL_SLOTS  = 5;

  // next value of a counter that stops at lim
  function automatic int sat_next(input int cur, input int lim, input bit inc);
    if (inc && cur < lim) return cur + 1;
    return cur;
  endfunction

  // slot k is written when the pointer equals k and a capture is accepted
  function automatic bit slot_sel(input int ptr, input int k, input bit en);
    return en && (ptr == k);
  endfunction

endpackage

// File: rtl/fl_accum.sv
module fl_accum #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [DATA_W-1:0] miss_vec,
  output logic [DATA_W-1:0] mask,
  output logic              flag
);

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_m,
                                               input logic [DATA_W-1:0] add_m);
    return old_m | add_m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      flag <= 1'b0;
    end else if (clr) begin
      mask <= '0;
      flag <= 1'b0;
    end else if (upd) begin
      mask <= merge(mask, miss_vec);
      if (|miss_vec) flag <= 1'b1;
    end
  end

endmodule

// File: rtl/fl_counter.sv
module fl_counter #(
  parameter int SLOTS = 5,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= CNT_W'(fl_pkg::sat_next(int'(count), SLOTS, hit));
  end

  assign full = (int'(count) >= SLOTS);

endmodule

// File: rtl/fl_slot_store.sv
module fl_slot_store #(
  parameter int SLOTS  = 5,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_ptr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [DATA_W-1:0] data_q [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic sel;
    assign sel = fl_pkg::slot_sel(int'(wr_ptr), k, wr_en);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[k] <= '0;
        data_q[k] <= '0;
      end else if (clr) begin
        addr_q[k] <= '0;
        data_q[k] <= '0;
      end else if (sel) begin
        addr_q[k] <= wr_addr;
        data_q[k] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_addr = '0;
    rd_data = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (int'(rd_idx) == k) begin
        rd_addr = addr_q[k];
        rd_data = data_q[k];
      end
    end
  end

endmodule

// File: rtl/fail_log_capture.sv
module fail_log_capture #(
  parameter int DATA_W = fl_pkg::FL_DATA_W,
  parameter int ADDR_W = fl_pkg::FL_ADDR_W,
  parameter int SLOTS  = fl_pkg::FL_SLOTS,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_start,
  input  logic              cmp_valid,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [DATA_W-1:0] cmp_exp,
  input  logic [DATA_W-1:0] cmp_rd,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] bit_fail_mask,
  output logic              fail_flag,
  output logic [CNT_W-1:0]  fail_count,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  // named internal events, visible to the bound checker
  logic [DATA_W-1:0] miss_vec;
  logic              cmp_take;
  logic              cmp_fail;
  logic              slots_full;
  logic              capture_en;

  assign miss_vec   = cmp_exp ^ cmp_rd;
  assign cmp_take   = cmp_valid && !run_start;
  assign cmp_fail   = cmp_take && (|miss_vec);
  assign capture_en = cmp_fail && !slots_full;

  fl_accum #(.DATA_W(DATA_W)) accum_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (run_start),
    .upd      (cmp_take),
    .miss_vec (miss_vec),
    .mask     (bit_fail_mask),
    .flag     (fail_flag)
  );

  fl_counter #(.SLOTS(SLOTS), .CNT_W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (run_start),
    .hit   (cmp_fail),
    .count (fail_count),
    .full  (slots_full)
  );

  fl_slot_store #(
    .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (run_start),
    .wr_en   (capture_en),
    .wr_ptr  (fail_count),
    .wr_addr (cmp_addr),
    .wr_data (cmp_rd),
    .rd_idx  (rd_idx),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 5,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_start,
  input logic              cmp_valid,
  input logic [DATA_W-1:0] miss_vec,
  input logic              cmp_fail,
  input logic [DATA_W-1:0] bit_fail_mask,
  input logic              fail_flag,
  input logic [CNT_W-1:0]  fail_count
);

  assert_mask_covers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !run_start) |=> ((bit_fail_mask & $past(miss_vec)) == $past(miss_vec)));

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !run_start) |=> fail_flag);

  assert_flag_matches_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag == (bit_fail_mask != '0));

  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !run_start) |=> ($stable(bit_fail_mask) && $stable(fail_flag) && $stable(fail_count)));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fail && int'(fail_count) < SLOTS) |=> (int'(fail_count) == int'($past(fail_count)) + 1));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fail_count) <= SLOTS);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (fail_count == '0 && bit_fail_mask == '0 && !fail_flag));

endmodule

bind fail_log_capture fl_checker #(
  .DATA_W(DATA_W), .SLOTS(SLOTS), .CNT_W(CNT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .run_start     (run_start),
  .cmp_valid     (cmp_valid),
  .miss_vec      (miss_vec),
  .cmp_fail      (cmp_fail),
  .bit_fail_mask (bit_fail_mask),
  .fail_flag     (fail_flag),
  .fail_count    (fail_count)
);

// File: tb/fail_log_capture_tb_top.sv
module fail_log_capture_tb_top;

  localparam int DW = 16;
  localparam int AW = 12;
  localparam int NS = 5;
  localparam int CW = $clog2(NS + 1);
  localparam int IW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_start = 1'b0;
  logic          cmp_valid = 1'b0;
  logic [AW-1:0] cmp_addr = '0;
  logic [DW-1:0] cmp_exp = '0;
  logic [DW-1:0] cmp_rd = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [DW-1:0] bit_fail_mask;
  logic          fail_flag;
  logic [CW-1:0] fail_count;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  fail_log_capture dut_i (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .cmp_valid(cmp_valid),
    .cmp_addr(cmp_addr), .cmp_exp(cmp_exp), .cmp_rd(cmp_rd), .rd_idx(rd_idx),
    .bit_fail_mask(bit_fail_mask), .fail_flag(fail_flag), .fail_count(fail_count),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [DW-1:0] m_mask;
  bit            m_flag;
  int            m_cnt;
  logic [AW-1:0] m_addr [NS];
  logic [DW-1:0] m_data [NS];

  function automatic logic [DW-1:0] exp_mask(input logic [DW-1:0] old_m,
                                             input logic [DW-1:0] e,
                                             input logic [DW-1:0] r);
    logic [DW-1:0] m;
    m = old_m;
    for (int b = 0; b < DW; b++) if (e[b] != r[b]) m[b] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic model_clear();
    m_mask = '0; m_flag = 0; m_cnt = 0;
    for (int k = 0; k < NS; k++) begin m_addr[k] = '0; m_data[k] = '0; end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " mask"}, 64'(bit_fail_mask), 64'(m_mask));
    chk({tag, " flag"}, 64'(fail_flag), 64'(m_flag));
    chk({tag, " count"}, 64'(fail_count), 64'(m_cnt));
  endtask

  task automatic check_slots(input string tag);
    for (int k = 0; k < 8; k++) begin
      rd_idx = IW'(k);
      #1;
      chk({tag, " slot addr"}, 64'(rd_addr), (k < NS) ? 64'(m_addr[k]) : 64'd0);
      chk({tag, " slot data"}, 64'(rd_data), (k < NS) ? 64'(m_data[k]) : 64'd0);
    end
  endtask

  // drive one cycle at negedge, update model, check after the edge
  task automatic step(input bit st, input bit v, input logic [AW-1:0] a,
                      input logic [DW-1:0] e, input logic [DW-1:0] r, input string tag);
    run_start = st; cmp_valid = v; cmp_addr = a; cmp_exp = e; cmp_rd = r;
    if (st) model_clear();
    else if (v) begin
      m_mask = exp_mask(m_mask, e, r);
      if (e != r) begin
        m_flag = 1;
        if (m_cnt < NS) begin m_addr[m_cnt] = a; m_data[m_cnt] = r; m_cnt++; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    run_start = 0; cmp_valid = 0;
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");
    check_slots("R1 R8 reset");

    // R9: equal data changes nothing
    step(0, 1, 12'h111, 16'hA5A5, 16'hA5A5, "R9 match");
    // R4: strobe low with differing data
    step(0, 0, 12'h222, 16'hFFFF, 16'h0000, "R4 idle");
    check_slots("R4 idle");
    // R2 R3 R5: first failure
    step(0, 1, 12'h0AB, 16'h00F0, 16'h0010, "R2 R3 R5 first");
    chk("R5 first count", 64'(fail_count), 64'd1);
    check_slots("R5 first");
    // R6: fill and overflow
    for (int i = 0; i < 6; i++)
      step(0, 1, AW'(12'h300 + i), 16'h0000, DW'(16'h1 << i), "R6 fill");
    chk("R6 saturated count", 64'(fail_count), 64'(NS));
    check_slots("R6 saturated");
    chk("R6 mask after overflow", 64'(bit_fail_mask[4]), 64'd1);
    // R8: out of range index
    rd_idx = IW'(NS); #1;
    chk("R8 out of range addr", 64'(rd_addr), 64'd0);
    // R7: start with simultaneous failing compare
    step(1, 1, 12'hFFF, 16'hFFFF, 16'h0000, "R7 clear priority");
    check_slots("R7 cleared");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit st, v;
      logic [DW-1:0] e, r;
      st = ($urandom_range(0, 99) < 2);
      v  = ($urandom_range(0, 99) < 70);
      e  = DW'($urandom);
      r  = ($urandom_range(0, 99) < 60) ? e : (e ^ DW'(1 << $urandom_range(0, DW-1)));
      step(st, v, AW'($urandom), e, r, "R2 R3 R5 R6 R7 random");
      if (i % 97 == 0) check_slots("R5 R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule